// File: doc/BRIEF.md
# Integer ALU with Forced-Add Overrides

This block is the arithmetic and logic unit of a 32-bit integer datapath. It is purely combinational. It takes two operands that the surrounding datapath has already selected, plus the instruction's 3-bit function field, bit 5 of its 7-bit function field, and a flag marking an immediate-format instruction. From these it produces a result word and a flag that is high when the result is all zero.

Three override inputs force an addition whatever the function bits hold. The first is for immediate arithmetic, the second for load/store address generation (base plus offset), and the third for branch and jump targets (PC plus offset). Function fields copied from a non-arithmetic instruction therefore never turn these calculations into a subtraction, a shift or a comparison. The operation chosen never depends on whether operand A came from the register file or the PC, or whether operand B came from the register file or the immediate generator.

Top module: `alu_forced_add`

## Requirements
- R1: When any of `ovr_imm_i`, `ovr_store_i` or `ovr_branch_i` is 1, `result_o` equals `opa_i + opb_i` modulo 2^32, whatever the values of `funct3_i`, `funct7b5_i` and `imm_fmt_i`.
- R2: With no override and `funct3_i` = 3'b000, `result_o` is `opa_i - opb_i` modulo 2^32 only when `imm_fmt_i` = 0 and `funct7b5_i` = 1. In every other case it is `opa_i + opb_i`.
- R3: With no override and `funct3_i` = 3'b001, `result_o` is `opa_i` shifted left by `opb_i[4:0]`, with zeros filled in. Bits 31:5 of `opb_i` have no effect.
- R4: With no override and `funct3_i` = 3'b101, `result_o` is `opa_i` shifted right by `opb_i[4:0]`. The shift is arithmetic (sign-filled) when `funct7b5_i` = 1 and logical (zero-filled) otherwise, for either value of `imm_fmt_i`.
- R5: With no override and `funct3_i` = 3'b010, `result_o` is 1 when `opa_i` < `opb_i` as two's-complement numbers and 0 otherwise. Bits 31:1 are always 0.
- R6: With no override and `funct3_i` = 3'b011, `result_o` is 1 when `opa_i` < `opb_i` as unsigned numbers and 0 otherwise. Bits 31:1 are always 0.
- R7: With no override, `funct3_i` = 3'b100 gives the bitwise XOR of the operands, 3'b110 gives the bitwise OR, and 3'b111 gives the bitwise AND.
- R8: `zero_o` is 1 exactly when `result_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Operand A (register value or PC) |
| opb_i | input | 32 | Operand B (register value or immediate) |
| funct3_i | input | 3 | Operation selector from the instruction |
| funct7b5_i | input | 1 | Subtract / arithmetic-shift qualifier bit |
| imm_fmt_i | input | 1 | 1 for immediate-format instructions |
| ovr_imm_i | input | 1 | Force addition for immediate arithmetic |
| ovr_store_i | input | 1 | Force addition for address generation |
| ovr_branch_i | input | 1 | Force addition for branch target generation |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The bench drives every combination of function field, qualifier bit, format flag and override pattern across a grid of edge operands. The grid includes zero, one, both sign extremes, all-ones and shift amounts of 31 and 32. An immediate add whose qualifier bit is set would come out as a subtraction if the format flag were ignored, and an override that failed to dominate would let a shift or comparison through on an address calculation. A shifter that used six amount bits would return zero for an amount of 32 instead of the unshifted operand. A comparator with the wrong signedness would disagree at 0x80000000 against 0x7FFFFFFF, and an arithmetic shift that filled with zeros would give a wrong result for every negative operand.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_SLL,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_SRL,
        OP_SRA,
        OP_OR,
        OP_AND
    } alu_op_e;

    localparam logic [2:0] F3_ADDSUB = 3'b000;
    localparam logic [2:0] F3_SLL    = 3'b001;
    localparam logic [2:0] F3_SLT    = 3'b010;
    localparam logic [2:0] F3_SLTU   = 3'b011;
    localparam logic [2:0] F3_XOR    = 3'b100;
    localparam logic [2:0] F3_SHR    = 3'b101;
    localparam logic [2:0] F3_OR     = 3'b110;
    localparam logic [2:0] F3_AND    = 3'b111;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [2:0] funct3_i,
    input  logic       funct7b5_i,
    input  logic       imm_fmt_i,
    input  logic       force_add_i,
    output alu_op_e    op_o
);
    alu_op_e op_d;

    always_comb begin
        op_d = OP_ADD;
        if (!force_add_i) begin
            unique case (funct3_i)
                F3_ADDSUB: op_d = (funct7b5_i && !imm_fmt_i) ? OP_SUB : OP_ADD;
                F3_SLL:    op_d = OP_SLL;
                F3_SLT:    op_d = OP_SLT;
                F3_SLTU:   op_d = OP_SLTU;
                F3_XOR:    op_d = OP_XOR;
                F3_SHR:    op_d = funct7b5_i ? OP_SRA : OP_SRL;
                F3_OR:     op_d = OP_OR;
                F3_AND:    op_d = OP_AND;
                default:   op_d = OP_ADD;
            endcase
        end
    end

    assign op_o = op_d;
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] data_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic            left_i,
    input  logic            arith_i,
    output logic [XLEN-1:0] data_o
);
    logic [XLEN-1:0] rev_in;
    logic [XLEN-1:0] rev_out;
    logic [XLEN-1:0] stage [SHW+1];
    logic            fill;

    generate
        for (genvar b = 0; b < XLEN; b++) begin : g_rev
            assign rev_in[b]  = data_i[XLEN-1-b];
            assign rev_out[b] = stage[SHW][XLEN-1-b];
        end
    endgenerate

    assign fill     = arith_i & ~left_i & data_i[XLEN-1];
    assign stage[0] = left_i ? rev_in : data_i;

    generate
        for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int DIST = 1 << s;
            assign stage[s+1] = amt_i[s]
                ? {{DIST{fill}}, stage[s][XLEN-1:DIST]}
                : stage[s];
        end
    endgenerate

    assign data_o = left_i ? rev_out : stage[SHW];
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            lt_signed_o,
    output logic            lt_unsigned_o
);
    logic [XLEN:0] diff;

    assign diff          = {1'b0, a_i} - {1'b0, b_i};
    assign lt_unsigned_o = diff[XLEN];
    assign lt_signed_o   = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : diff[XLEN];
endmodule

// File: rtl/alu_forced_add.sv
module alu_forced_add
    import alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [2:0]      funct3_i,
    input  logic            funct7b5_i,
    input  logic            imm_fmt_i,
    input  logic            ovr_imm_i,
    input  logic            ovr_store_i,
    input  logic            ovr_branch_i,
    output logic [XLEN-1:0] result_o,
    output logic            zero_o
);
    localparam int SHW = $clog2(XLEN);

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            zero;
    } alu_out_t;

    alu_op_e         op;
    logic            force_add;
    logic [XLEN-1:0] shift_res;
    logic            lt_s;
    logic            lt_u;
    alu_out_t        out_d;

    assign force_add = ovr_imm_i | ovr_store_i | ovr_branch_i;

    alu_decode u_decode (
        .funct3_i    (funct3_i),
        .funct7b5_i  (funct7b5_i),
        .imm_fmt_i   (imm_fmt_i),
        .force_add_i (force_add),
        .op_o        (op)
    );

    alu_shifter #(.XLEN(XLEN)) u_shift (
        .data_i  (opa_i),
        .amt_i   (opb_i[SHW-1:0]),
        .left_i  (op == OP_SLL),
        .arith_i (op == OP_SRA),
        .data_o  (shift_res)
    );

    alu_compare #(.XLEN(XLEN)) u_cmp (
        .a_i           (opa_i),
        .b_i           (opb_i),
        .lt_signed_o   (lt_s),
        .lt_unsigned_o (lt_u)
    );

    always_comb begin
        out_d = '0;
        unique case (op)
            OP_ADD:  out_d.result = opa_i + opb_i;
            OP_SUB:  out_d.result = opa_i - opb_i;
            OP_SLL,
            OP_SRL,
            OP_SRA:  out_d.result = shift_res;
            OP_SLT:  out_d.result = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: out_d.result = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:  out_d.result = opa_i ^ opb_i;
            OP_OR:   out_d.result = opa_i | opb_i;
            OP_AND:  out_d.result = opa_i & opb_i;
            default: out_d.result = opa_i + opb_i;
        endcase
        out_d.zero = ~|out_d.result;
    end

    assign result_o = out_d.result;
    assign zero_o   = out_d.zero;
endmodule

module alu_forced_add_chk #(
    parameter int XLEN = 32
) (
    input logic [XLEN-1:0] opa_i,
    input logic [XLEN-1:0] opb_i,
    input logic [2:0]      funct3_i,
    input logic            funct7b5_i,
    input logic            imm_fmt_i,
    input logic            ovr_imm_i,
    input logic            ovr_store_i,
    input logic            ovr_branch_i,
    input logic [XLEN-1:0] result_o,
    input logic            zero_o
);
    logic no_ovr;
    assign no_ovr = !(ovr_imm_i || ovr_store_i || ovr_branch_i);

    always_comb begin
        AST_FORCED_ADD: assert (no_ovr || result_o == opa_i + opb_i); // R1
        AST_IMM_NEVER_SUB: assert (!(no_ovr && funct3_i == 3'b000 && imm_fmt_i)
                                   || result_o == opa_i + opb_i); // R2
        AST_SLT_ONE_BIT: assert (!(no_ovr && funct3_i == 3'b010)
                                 || result_o[XLEN-1:1] == '0); // R5
        AST_SLTU_ONE_BIT: assert (!(no_ovr && funct3_i == 3'b011)
                                  || result_o[XLEN-1:1] == '0); // R6
        AST_OR_COVERS: assert (!(no_ovr && funct3_i == 3'b110)
                               || (result_o & opa_i & opb_i) == (opa_i & opb_i)); // R7
        AST_AND_INSIDE: assert (!(no_ovr && funct3_i == 3'b111)
                                || (result_o & ~opa_i) == '0); // R7
        AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R8
    end
endmodule

bind alu_forced_add alu_forced_add_chk #(.XLEN(XLEN)) u_chk (
    .opa_i        (opa_i),
    .opb_i        (opb_i),
    .funct3_i     (funct3_i),
    .funct7b5_i   (funct7b5_i),
    .imm_fmt_i    (imm_fmt_i),
    .ovr_imm_i    (ovr_imm_i),
    .ovr_store_i  (ovr_store_i),
    .ovr_branch_i (ovr_branch_i),
    .result_o     (result_o),
    .zero_o       (zero_o)
);

// File: tb/alu_forced_add_tb.sv
module alu_forced_add_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam longint MASK = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa, opb;
    logic [2:0]  f3;
    logic        f7, immf, o_imm, o_st, o_br;
    logic [31:0] res;
    logic        zf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_forced_add dut_i (
        .opa_i(opa), .opb_i(opb), .funct3_i(f3), .funct7b5_i(f7),
        .imm_fmt_i(immf), .ovr_imm_i(o_imm), .ovr_store_i(o_st),
        .ovr_branch_i(o_br), .result_o(res), .zero_o(zf)
    );

    function automatic longint to_signed(input logic [31:0] v);
        longint x = longint'(v);
        return (x >= 64'h8000_0000) ? x - 64'h1_0000_0000 : x;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] fn, input logic q, input logic imm,
                                          input logic ovr);
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint sa = to_signed(a);
        longint sb = to_signed(b);
        int     sh = int'(ub % 32);
        longint p  = longint'(1) << sh;
        longint r;
        if (ovr) return 32'((ua + ub) & MASK);              // R1
        case (fn)
            3'd0: r = (q && !imm) ? (ua - ub) : (ua + ub);   // R2
            3'd1: r = ua * p;                                // R3
            3'd2: r = (sa < sb) ? 1 : 0;                     // R5
            3'd3: r = (ua < ub) ? 1 : 0;                     // R6
            3'd4: r = longint'(a ^ b);                       // R7
            3'd5: r = q ? ((sa >= 0) ? sa / p : -((-sa - 1) / p) - 1) : ua / p; // R4
            3'd6: r = longint'(a | b);
            default: r = longint'(a & b);
        endcase
        return 32'(r & MASK);
    endfunction

    function automatic string req_of(input logic [2:0] fn, input logic ovr);
        if (ovr) return "R1";
        case (fn)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd5: return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] a, input logic [31:0] b, input logic [2:0] fn,
                               input logic q, input logic imm, input logic [2:0] ov);
        logic [31:0] exp;
        @(negedge clk);
        opa = a; opb = b; f3 = fn; f7 = q; immf = imm;
        {o_imm, o_st, o_br} = ov;
        #1;
        exp = model(a, b, fn, q, imm, |ov);
        n_chk++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s f3=%0d q=%0d imm=%0d ov=%b a=%h b=%h actual=%h expected=%h",
                     req_of(fn, |ov), fn, q, imm, ov, a, b, res, exp);
        end
        n_chk++;
        if (zf !== (exp == 32'd0)) begin
            n_fail++;
            $display("FAIL R8 a=%h b=%h actual zero=%0d expected=%0d", a, b, zf, exp == 32'd0);
        end
    endtask

    logic [31:0] corner [10];

    initial begin
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
        corner[4] = 32'hFFFF_FFFF; corner[5] = 32'h0000_001F;
        corner[6] = 32'h0000_0020; corner[7] = 32'hA5A5_3C3F;
        corner[8] = 32'hFFFF_FFE4; corner[9] = 32'h1234_5678;
        opa = '0; opb = '0; f3 = '0; f7 = 1'b0; immf = 1'b0;
        o_imm = 1'b0; o_st = 1'b0; o_br = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset/idle state: all-zero inputs give a zero sum and a raised zero flag (R2, R8)
        @(negedge clk);
        n_chk++;
        if (res !== 32'd0 || zf !== 1'b1) begin
            n_fail++;
            $display("FAIL R8 idle actual=%h/%0d expected=00000000/1", res, zf);
        end
        // sweep every control combination over the operand grid (R1..R8)
        for (int fn = 0; fn < 8; fn++)
            for (int ctl = 0; ctl < 32; ctl++)
                for (int i = 0; i < 10; i++)
                    for (int j = 0; j < 10; j++)
                        apply_check(corner[i], corner[j], 3'(fn), ctl[0], ctl[1], 3'(ctl >> 2));
        // R3, R4: every shift amount with garbage in the upper amount bits
        for (int s = 0; s < 32; s++) begin
            apply_check(32'h8000_0001, 32'hFFFF_FFE0 | 32'(s), 3'd1, 1'b0, 1'b1, 3'b000);
            apply_check(32'h8765_4321, 32'h0000_0040 | 32'(s), 3'd5, 1'b1, 1'b1, 3'b000);
            apply_check(32'h8765_4321, 32'h0000_0040 | 32'(s), 3'd5, 1'b0, 1'b0, 3'b000);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule